// File: doc/BRIEF.md
# PC-Style Parallel Port Register Interface

This block places a three-register parallel port on a simple synchronous host bus. A data register drives the eight data pins. A status register presents the port's input handshake lines. A control register drives the four output strobes, holds the data direction bit and holds an interrupt enable. Several fields are stored or returned inverted relative to the pins, so software sees a uniform "1 means active" view.

A host issues single-cycle writes and reads over a 2-bit address. Read data comes back one clock after the read strobe, qualified by a valid flag. The data register does not read back what was written. It returns the value present on the data lines at that moment, so the same address serves for output and for reverse-direction input. The acknowledge input passes through a synchronizer. When the interrupt enable is set, each rising edge of that input produces a one-cycle interrupt pulse.

Top module: `pport_regs`

## Requirements
- R1: After reset the control register is zero. The pins then sit at strobe_n=1, autofd_n=1, selin_n=1 and init_n=0, with pd_oe=1, pd_out=0 and irq=0.
- R2: A write to address 0 places bus_wdata on pd_out from the next cycle on. A read of address 0 returns the value of pd_in, not the last value written.
- R3: A read of address 1 returns a status byte. Bit 7 is the inverse of busy_in. Bit 6 is ack_n, bit 5 is paper_out, bit 4 is online, bit 3 is fault_n, and bits 2:0 read as 0.
- R4: Writes to address 1 or address 3 change neither pd_out nor the control register.
- R5: A write to address 2 stores bits 5:0 as the control register. A read of address 2 returns those six bits, with bits 7:6 reading as 0.
- R6: The control bits map to the pins as follows. Bit 0 drives strobe_n inverted, bit 1 drives autofd_n inverted, bit 3 drives selin_n inverted, and bit 2 drives init_n without inversion.
- R7: pd_oe is low only while control bit 5 (direction) is 1 and ext_mode is 1. With ext_mode at 0 the data pins are driven whatever the direction bit says.
- R8: While control bit 4 is 1, each rising edge of ack_n yields exactly one irq pulse, one cycle wide, three clocks after the edge is first sampled. No pulse follows a falling edge or occurs while bit 4 is 0.
- R9: A read of address 3 returns 0.
- R10: bus_rvalid is high exactly in the cycle after a cycle with bus_rd high, and bus_rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ext_mode | input | 1 | 1 = extended mode, in which the direction bit takes effect |
| pd_in | input | 8 | Data lines as seen at the pins |
| pd_out | output | 8 | Data to drive onto the data lines |
| pd_oe | output | 1 | Data driver enable |
| busy_in | input | 1 | Peripheral busy line |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| paper_out | input | 1 | Peripheral paper error line |
| online | input | 1 | Peripheral select line |
| fault_n | input | 1 | Peripheral fault, active low |
| strobe_n | output | 1 | Data strobe, active low |
| autofd_n | output | 1 | Auto line feed, active low |
| init_n | output | 1 | Peripheral initialize, active low |
| selin_n | output | 1 | Select-in, active low |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checks assume that ext_mode does not change in the cycle that follows a control write, and that no read and write are issued in the same cycle. The stimulus changes ext_mode and the pin inputs only after a write has had an idle cycle to take effect, and it issues every bus access on its own. The acknowledge input is treated as asynchronous, but the bench holds each level for at least four clocks so that every edge passes through the synchronizer. Under these conditions the pulse timing and the pin mapping are fixed to the cycle.

// File: rtl/pport_regs.sv
module pport_regs #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              ext_mode,
  input  logic [DATA_W-1:0] pd_in,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic              busy_in,
  input  logic              ack_n,
  input  logic              paper_out,
  input  logic              online,
  input  logic              fault_n,
  output logic              strobe_n,
  output logic              autofd_n,
  output logic              init_n,
  output logic              selin_n,
  output logic              irq
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam int CTL_W = 6;
  localparam int B_STB = 0, B_AFD = 1, B_INI = 2, B_SEL = 3, B_IEN = 4, B_DIR = 5;

  logic [DATA_W-1:0]    data_q;
  logic [CTL_W-1:0]     ctl_q;
  logic [SYNC_STAGES:0] ack_sync;
  logic [DATA_W-1:0]    rd_mux;
  logic [DATA_W-1:0]    stat_byte;
  logic                 ack_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DATA) data_q <= bus_wdata;
      if (bus_addr == A_CTRL) ctl_q  <= bus_wdata[CTL_W-1:0];
    end
  end

  assign stat_byte = DATA_W'({~busy_in, ack_n, paper_out, online, fault_n, 3'b000});

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_mux = pd_in;
      A_STAT:  rd_mux = stat_byte;
      A_CTRL:  rd_mux = DATA_W'(ctl_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_sync <= '1;
      irq      <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-1:0], ack_n};
      irq      <= ctl_q[B_IEN] & ack_rise;
    end
  end

  assign ack_rise = ack_sync[SYNC_STAGES-1] & ~ack_sync[SYNC_STAGES];

  assign pd_out   = data_q;
  assign pd_oe    = ~(ext_mode & ctl_q[B_DIR]);
  assign strobe_n = ~ctl_q[B_STB];
  assign autofd_n = ~ctl_q[B_AFD];
  assign init_n   =  ctl_q[B_INI];
  assign selin_n  = ~ctl_q[B_SEL];
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       bus_rvalid,
  input logic       ext_mode,
  input logic [7:0] pd_out,
  input logic       pd_oe,
  input logic       strobe_n,
  input logic       init_n,
  input logic       irq
);
  a_r2_data_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> pd_out == $past(bus_wdata));

  a_r4_stat_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> $stable(pd_out) && $stable(strobe_n) && $stable(init_n));

  a_r6_strobe_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> strobe_n == !$past(bus_wdata[0]));

  a_r6_init_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> init_n == $past(bus_wdata[2]));

  a_r7_dir_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && bus_wdata[5] && ext_mode) |=> !pd_oe);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_addr3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata == 8'h00);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> bus_rdata[2:0] == 3'b000);

  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r10_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind pport_regs pport_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .ext_mode(ext_mode), .pd_out(pd_out),
  .pd_oe(pd_oe), .strobe_n(strobe_n), .init_n(init_n), .irq(irq)
);

// File: tb/pport_regs_bench.sv
module pport_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, pd_in = '0;
  logic ext_mode = 1'b0;
  logic busy_in = 1'b0, ack_n = 1'b1, paper_out = 1'b0, online = 1'b0, fault_n = 1'b1;
  logic [7:0] bus_rdata, pd_out;
  logic bus_rvalid, pd_oe, strobe_n, autofd_n, init_n, selin_n, irq;

  int nvec = 0, nbad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pport_regs u_pport_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ext_mode(ext_mode), .pd_in(pd_in),
    .pd_out(pd_out), .pd_oe(pd_oe), .busy_in(busy_in), .ack_n(ack_n),
    .paper_out(paper_out), .online(online), .fault_n(fault_n),
    .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
    .selin_n(selin_n), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 8'h01, 8'h00);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [7:0] pins();
    return {4'b0, selin_n, init_n, autofd_n, strobe_n};
  endfunction

  task automatic irq_probe(logic exp, string tag);
    ack_n = 1'b0;
    repeat (4) @(negedge clk);
    check({tag, " falling edge"}, {7'b0, irq}, 8'h00);
    ack_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check({tag, " early"}, {7'b0, irq}, 8'h00);
    end
    @(negedge clk);
    check({tag, " pulse"}, {7'b0, irq}, {7'b0, exp});
    @(negedge clk);
    check({tag, " width"}, {7'b0, irq}, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset pins", pins(), 8'b0000_1011);
    check("R1 reset oe/irq", {6'b0, pd_oe, irq}, 8'h02);
    check("R1 reset pd_out", pd_out, 8'h00);
    rd(2'd2, 8'h00, "R1 reset ctl read");
    // R2
    wr(2'd0, 8'hA5);
    check("R2 pd_out", pd_out, 8'hA5);
    pd_in = 8'h3C;
    rd(2'd0, 8'h3C, "R2 data read live pins");
    pd_in = 8'hC3;
    rd(2'd0, 8'hC3, "R2 data read second pattern");
    // R3
    busy_in = 1'b1; ack_n = 1'b1; paper_out = 1'b0; online = 1'b1; fault_n = 1'b0;
    rd(2'd1, 8'b0101_0000, "R3 status pattern A");
    busy_in = 1'b0; ack_n = 1'b0; paper_out = 1'b1; online = 1'b0; fault_n = 1'b1;
    rd(2'd1, 8'b1010_1000, "R3 status pattern B");
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5 / R6
    wr(2'd2, 8'hC5);
    check("R6 pins after 05", pins(), 8'b0000_1110);
    rd(2'd2, 8'h05, "R5 ctl readback upper zero");
    wr(2'd2, 8'h0A);
    check("R6 pins after 0A", pins(), 8'b0000_0001);
    rd(2'd2, 8'h0A, "R5 ctl readback 0A");
    // R4
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h55);
    check("R4 pd_out unchanged", pd_out, 8'hA5);
    rd(2'd2, 8'h0A, "R4 ctl unchanged");
    // R9
    rd(2'd3, 8'h00, "R9 addr3 read");
    // R7
    wr(2'd2, 8'h20);
    check("R7 dir, compat mode", {7'b0, pd_oe}, 8'h01);
    ext_mode = 1'b1;
    @(negedge clk);
    check("R7 dir, extended mode", {7'b0, pd_oe}, 8'h00);
    wr(2'd2, 8'h00);
    check("R7 dir cleared", {7'b0, pd_oe}, 8'h01);
    ext_mode = 1'b0;
    @(negedge clk);
    // R8
    irq_probe(1'b0, "R8 disabled");
    wr(2'd2, 8'h10);
    irq_probe(1'b1, "R8 enabled");
    irq_probe(1'b1, "R8 enabled second edge");
    // R10: drain scoreboard
    repeat (4) @(negedge clk);
    check("R10 all reads returned", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule